// File: doc/BRIEF.md
# Maskable Interrupt Request Arbiter

This block sits between a set of interrupt request lines and a processor core. It watches sixteen maskable request lines, plus one non-maskable line. Each maskable line has a pending bit, which records that a request arrived. It also has an in-service bit, which marks that the core has accepted that vector and is still handling it. Each clock cycle the block picks at most one candidate. It shows that candidate on a registered valid / vector / non-maskable-flag output. The candidate stays offered until the core raises the acknowledge input.

Vector number 0 is the highest priority. A maskable vector is offered only while the global enable is high. It must also outrank every vector that is currently in service. If the enable is low, requests keep accumulating as pending bits and none is lost. Each vector can buffer at most two occurrences: one pending and one in service. A further arrival while the pending bit is set leaves no trace.

The non-maskable line is detected on its rising edge and kept in its own pending flag. It ignores the enable and outranks every maskable vector. A separate in-service flag, cleared by its own end-of-interrupt input, allows only one non-maskable delivery at a time.

Top module: `irq_arbiter`

## Requirements
- R1: While the synchronous reset is high, and on the first clock after it, `irq_valid` is 0. All pending and in-service state is cleared.
- R2: A maskable request arriving while `irq_en` is low is kept as pending and is not offered. After `irq_en` goes high it is offered.
- R3: A request on a vector whose pending bit is already set is dropped. After that vector is served and retired once, nothing more is offered for it.
- R4: Of the eligible pending maskable vectors, the one with the lowest number is offered. `irq_vector` carries the vector number in binary, and `irq_nmi` is 0.
- R5: Requests on several lines in the same cycle are all recorded. They are delivered one per handshake, in ascending vector order.
- R6: A pending maskable vector is offered only if its number is strictly below that of every in-service vector.
- R7: A cycle with `irq_valid` and `ack` both high moves an offered maskable vector from pending to in service. `irq_valid` is then 0 on the following cycle.
- R8: An `eoi` pulse clears only the in-service bit with the lowest vector number.
- R9: A request on a vector in the same cycle that its pending bit is cleared by acknowledge is kept as a new pending request.
- R10: A rising edge of `nmi_req` is offered with `irq_nmi`=1 and `irq_vector`=0. This happens whatever the state of `irq_en`, and ahead of any pending maskable vector.
- R11: After a non-maskable delivery is acknowledged, no further non-maskable delivery is offered until `nmi_eoi` has been pulsed.
- R12: A request captured at clock edge k is offered, if eligible, on the output registered at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | N_LINES | Maskable requests; a high bit in a cycle is one arrival |
| nmi_req | input | 1 | Non-maskable request, detected on its rising edge |
| irq_en | input | 1 | Global enable for maskable delivery |
| ack | input | 1 | Core accepts the offered interrupt |
| eoi | input | 1 | Retire the highest-priority maskable vector in service |
| nmi_eoi | input | 1 | Retire the non-maskable interrupt in service |
| irq_valid | output | 1 | An interrupt is being offered |
| irq_nmi | output | 1 | The offered interrupt is the non-maskable one |
| irq_vector | output | clog2(N_LINES) | Number of the offered maskable vector |

## Verification
Any wrong pending or in-service bit shows at the ports within about two clocks. A lost pending bit means a vector is never offered after the enable rises or after a retire. A stale in-service bit keeps lower-priority vectors blocked after `eoi`. A wrong retire order lets a lower-priority vector appear while a higher one should still block it. The bench runs a behavioural reference model and compares valid, vector and the non-maskable flag on every cycle, so a divergence is reported in the cycle it first reaches the outputs.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  parameter int unsigned IRQ_LINES_DEFAULT = 16;

  typedef struct packed {
    logic pend;
    logic insvc;
    logic prev;
  } nmi_state_t;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] pick_oh
);
  logic taken;

  always_comb begin
    pick_oh = '0;
    taken   = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (req[i] && !taken) begin
        pick_oh[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] arrive,
  input  logic [N_LINES-1:0] take_oh,
  input  logic [N_LINES-1:0] retire_oh,
  output logic [N_LINES-1:0] pend_q,
  output logic [N_LINES-1:0] insvc_q
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g]  <= 1'b0;
        insvc_q[g] <= 1'b0;
      end else begin
        // an arrival in the acknowledge cycle re-arms the pending bit
        pend_q[g]  <= (pend_q[g] & ~take_oh[g]) | arrive[g];
        insvc_q[g] <= (insvc_q[g] & ~retire_oh[g]) | take_oh[g];
      end
    end
  end
endmodule

// File: rtl/irq_nmi_track.sv
module irq_nmi_track
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nmi_req,
  input  logic nmi_take,
  input  logic nmi_retire,
  output logic nmi_ready,
  output logic nmi_busy
);
  nmi_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      st_q.prev  <= nmi_req;
      st_q.pend  <= (st_q.pend & ~nmi_take) | (nmi_req & ~st_q.prev);
      st_q.insvc <= (st_q.insvc & ~nmi_retire) | nmi_take;
    end
  end

  assign nmi_ready = st_q.pend & ~st_q.insvc;
  assign nmi_busy  = st_q.insvc;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_LINES = IRQ_LINES_DEFAULT,
  localparam int unsigned VW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               irq_en,
  input  logic               ack,
  input  logic               eoi,
  input  logic               nmi_eoi,
  output logic               irq_valid,
  output logic               irq_nmi,
  output logic [VW-1:0]      irq_vector
);
  logic               ack_hit;
  logic [N_LINES-1:0] take_oh;
  logic [N_LINES-1:0] retire_oh;
  logic [N_LINES-1:0] svc_low_oh;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] insvc_q;
  logic [N_LINES-1:0] blocked;
  logic [N_LINES-1:0] eligible;
  logic [N_LINES-1:0] sel_oh;
  logic [VW-1:0]      sel_idx;
  logic               nmi_ready;
  logic               nmi_insvc;

  assign ack_hit = ack & irq_valid;

  for (genvar g = 0; g < N_LINES; g++) begin : g_take
    assign take_oh[g] = ack_hit & ~irq_nmi & (irq_vector == VW'(g));
  end

  // blocked[i]: some vector numbered i or lower is in service
  assign blocked[0] = insvc_q[0];
  for (genvar g = 1; g < N_LINES; g++) begin : g_block
    assign blocked[g] = blocked[g-1] | insvc_q[g];
  end

  assign eligible  = pend_q & ~blocked & {N_LINES{irq_en}};
  assign retire_oh = eoi ? svc_low_oh : '0;

  irq_lowest_pick #(.WIDTH(N_LINES)) u_pick_sel (
    .req     (eligible),
    .pick_oh (sel_oh)
  );

  irq_lowest_pick #(.WIDTH(N_LINES)) u_pick_svc (
    .req     (insvc_q),
    .pick_oh (svc_low_oh)
  );

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (sel_oh[i]) sel_idx = sel_idx | VW'(i);
    end
  end

  irq_vec_bank #(.N_LINES(N_LINES)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .arrive    (irq_req),
    .take_oh   (take_oh),
    .retire_oh (retire_oh),
    .pend_q    (pend_q),
    .insvc_q   (insvc_q)
  );

  irq_nmi_track u_nmi (
    .clk        (clk),
    .rst        (rst),
    .nmi_req    (nmi_req),
    .nmi_take   (ack_hit & irq_nmi),
    .nmi_retire (nmi_eoi),
    .nmi_ready  (nmi_ready),
    .nmi_busy   (nmi_insvc)
  );

  always_ff @(posedge clk) begin
    if (rst || ack_hit) begin
      irq_valid  <= 1'b0;
      irq_nmi    <= 1'b0;
      irq_vector <= '0;
    end else if (nmi_ready) begin
      irq_valid  <= 1'b1;
      irq_nmi    <= 1'b1;
      irq_vector <= '0;
    end else begin
      irq_valid  <= |eligible;
      irq_nmi    <= 1'b0;
      irq_vector <= sel_idx;
    end
  end
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int unsigned N_LINES = 16,
  localparam int unsigned VW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_en,
  input logic               ack,
  input logic               eoi,
  input logic               irq_valid,
  input logic               irq_nmi,
  input logic [VW-1:0]      irq_vector,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] insvc_q,
  input logic               nmi_insvc
);
  logic [N_LINES-1:0] upto_vec;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) upto_vec[i] = (i <= int'(irq_vector));
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_valid);

  assert_enable_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_nmi) |-> $past(irq_en));

  assert_offer_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_nmi) |-> pend_q[irq_vector]);

  assert_above_service_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_nmi) |-> ((insvc_q & upto_vec) == '0));

  assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && ack) |=> !irq_valid);

  assert_into_service_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && ack && !irq_nmi) |=> insvc_q[$past(irq_vector)]);

  assert_retire_one_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi && (insvc_q != '0) && !(irq_valid && ack && !irq_nmi))
      |=> ($countones(insvc_q) == $countones($past(insvc_q)) - 1));

  assert_nmi_single_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_nmi) |-> !nmi_insvc);
endmodule

bind irq_arbiter irq_arb_checker #(.N_LINES(N_LINES)) u_irq_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_en     (irq_en),
  .ack        (ack),
  .eoi        (eoi),
  .irq_valid  (irq_valid),
  .irq_nmi    (irq_nmi),
  .irq_vector (irq_vector),
  .pend_q     (pend_q),
  .insvc_q    (insvc_q),
  .nmi_insvc  (nmi_insvc)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  localparam int N = 16;
  localparam int VW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_req = '0;
  logic nmi_req = 1'b0, irq_en = 1'b0, ack = 1'b0, eoi = 1'b0, nmi_eoi = 1'b0;
  logic irq_valid, irq_nmi;
  logic [VW-1:0] irq_vector;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  irq_arbiter #(.N_LINES(N)) i_irq_arbiter (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req), .irq_en(irq_en),
    .ack(ack), .eoi(eoi), .nmi_eoi(nmi_eoi),
    .irq_valid(irq_valid), .irq_nmi(irq_nmi), .irq_vector(irq_vector)
  );

  // behavioural reference model
  bit m_pend[N], m_svc[N];
  bit m_np, m_ns, m_nprev, m_v, m_nmi;
  int m_vec;
  bit t_ack, t_v, t_n, t_found;
  int t_vec, t_low;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_svc[i] = 0; end
      m_np = 0; m_ns = 0; m_nprev = 0; m_v = 0; m_nmi = 0; m_vec = 0;
    end else begin
      t_ack = ack && m_v;
      t_v = 0; t_n = 0; t_vec = 0;
      if (!t_ack) begin
        if (m_np && !m_ns) begin t_v = 1; t_n = 1; end
        else if (irq_en) begin
          t_low = N;
          for (int i = N - 1; i >= 0; i--) if (m_svc[i]) t_low = i;
          t_found = 0;
          for (int i = 0; i < t_low; i++)
            if (m_pend[i] && !t_found) begin t_found = 1; t_v = 1; t_vec = i; end
        end
      end
      if (eoi) begin
        t_found = 0;
        for (int i = 0; i < N; i++)
          if (m_svc[i] && !t_found) begin t_found = 1; m_svc[i] = 0; end
      end
      if (t_ack && !m_nmi) begin m_pend[m_vec] = 0; m_svc[m_vec] = 1; end
      for (int i = 0; i < N; i++) if (irq_req[i]) m_pend[i] = 1;
      m_ns = (m_ns && !nmi_eoi) || (t_ack && m_nmi);
      m_np = (m_np && !(t_ack && m_nmi)) || (nmi_req && !m_nprev);
      m_nprev = nmi_req;
      m_v = t_v; m_nmi = t_n; m_vec = t_vec;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (irq_valid !== m_v ||
          (m_v && (irq_nmi !== m_nmi || (!m_nmi && int'(irq_vector) != m_vec)))) begin
        mismatched++;
        $display("FAIL %s model: valid/nmi/vec actual %0b/%0b/%0d expected %0b/%0b/%0d",
                 phase, irq_valid, irq_nmi, irq_vector, m_v, m_nmi, m_vec);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_out(string tag, bit ev, bit en, int evec);
    compared++;
    if (irq_valid !== ev || (ev && (irq_nmi !== en || (!en && int'(irq_vector) != evec)))) begin
      mismatched++;
      $display("FAIL %s: valid/nmi/vec actual %0b/%0b/%0d expected %0b/%0b/%0d",
               tag, irq_valid, irq_nmi, irq_vector, ev, en, evec);
    end
  endtask

  task automatic pulse(logic [N-1:0] m);
    irq_req = m; tick(); irq_req = '0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic do_eoi();
    eoi = 1; tick(); eoi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    expect_out("R1 in reset", 0, 0, 0);
    rst = 0; tick();
    expect_out("R1 after reset", 0, 0, 0);

    phase = "R2";
    pulse(N'(1) << 5);
    tick(); tick(); tick();
    expect_out("R2 held while disabled", 0, 0, 0);
    irq_en = 1; tick(); tick();
    expect_out("R2 shown after enable", 1, 0, 5);

    phase = "R7";
    do_ack();
    expect_out("R7 valid drops after ack", 0, 0, 0);
    do_eoi(); tick();

    phase = "R3";
    irq_en = 0;
    pulse(N'(1) << 3); pulse(N'(1) << 3); pulse(N'(1) << 3);
    irq_en = 1; tick(); tick();
    expect_out("R3 first shown", 1, 0, 3);
    do_ack(); do_eoi(); tick(); tick();
    expect_out("R3 duplicates dropped", 0, 0, 0);

    phase = "R5";
    pulse((N'(1) << 9) | (N'(1) << 2) | (N'(1) << 12));
    tick();
    expect_out("R4 lowest first", 1, 0, 2);
    do_ack(); do_eoi(); tick();
    expect_out("R5 second", 1, 0, 9);
    do_ack(); do_eoi(); tick();
    expect_out("R5 third", 1, 0, 12);
    do_ack(); do_eoi(); tick();

    phase = "R6";
    pulse(N'(1) << 4); tick();
    expect_out("R12 two edges", 1, 0, 4);
    do_ack();
    pulse(N'(1) << 6); tick(); tick();
    expect_out("R6 lower blocked", 0, 0, 0);
    pulse(N'(1) << 1); tick();
    expect_out("R6 higher preempts", 1, 0, 1);
    do_ack();
    phase = "R8";
    do_eoi(); tick(); tick();
    expect_out("R8 only top retired", 0, 0, 0);
    do_eoi(); tick();
    expect_out("R8 second retire unblocks", 1, 0, 6);
    do_ack(); do_eoi(); tick();

    phase = "R9";
    pulse(N'(1) << 7); tick();
    expect_out("R9 shown", 1, 0, 7);
    ack = 1; irq_req = N'(1) << 7; tick(); ack = 0; irq_req = '0;
    tick();
    expect_out("R9 blocked by own service", 0, 0, 0);
    do_eoi(); tick();
    expect_out("R9 re-armed request", 1, 0, 7);
    do_ack(); do_eoi(); tick();

    phase = "R10";
    irq_en = 0;
    pulse(N'(1) << 2);
    nmi_req = 1; tick(); tick();
    expect_out("R10 nmi ignores enable", 1, 1, 0);
    irq_en = 1; tick();
    expect_out("R10 nmi outranks", 1, 1, 0);
    irq_en = 0;
    do_ack();
    phase = "R11";
    nmi_req = 0; tick(); nmi_req = 1; tick(); tick(); tick();
    expect_out("R11 second nmi held", 0, 0, 0);
    nmi_eoi = 1; tick(); nmi_eoi = 0; tick();
    expect_out("R11 after nmi eoi", 1, 1, 0);
    do_ack(); nmi_eoi = 1; tick(); nmi_eoi = 0; nmi_req = 0;
    irq_en = 1; tick(); tick();
    expect_out("R2 pending survives", 1, 0, 2);
    do_ack(); do_eoi(); tick();

    phase = "R4";
    for (int c = 0; c < 4000; c++) begin
      irq_req = N'($urandom & $urandom & $urandom);
      irq_en  = ($urandom % 8) != 0;
      ack     = $urandom % 2;
      eoi     = ($urandom % 5) == 0;
      nmi_eoi = ($urandom % 9) == 0;
      if (($urandom % 23) == 0) nmi_req = ~nmi_req;
      tick();
    end
    irq_req = '0; ack = 0; eoi = 0; nmi_eoi = 0;
    tick(); tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule